// File: doc/BRIEF.md
# Two-Stage Management Watchdog

This block is a register-mapped watchdog for system-management firmware. A countdown is loaded from a programmable timer value and moves down by one on every cycle in which the periodic tick input is high. When the countdown runs out, the block does not reset the system straight away. The first expiry only raises a status flag and, if enabled, pulses a management interrupt, and the countdown reloads itself. A second expiry in a row, with no software reload in between, flags a second timeout and pulses a reboot request. A strap input or a no-reboot input can veto that request.

Software controls the block over a simple register bus. Each register is 16 bits wide and has its own halfword index. Two byte strobes pick the lanes, and the low byte is lane 0. Every access completes in the cycle it is presented, so the bus has no handshake. Read data is combinational from the address. Besides the reload, timer, status and control registers, the block holds a data-in byte, a data-out byte, a message word, and an auxiliary word made of a watchdog-count byte and a software interrupt byte. Writes to data-in and data-out post status events.

Register map (halfword index): 0 reload, 1 data {out[15:8], in[7:0]}, 2 status-1, 3 status-2, 4 control-1, 5 control-2, 6 message, 7 timer value (low TMR_W bits), 8 auxiliary {swirq[15:8], wdcnt[7:0]}. Reads of unmapped indices return 0.

Top module: `mgmt_watchdog`

## Requirements
- R1: After reset, the timer value reads 4, control-2 reads 0x0008 and the auxiliary word reads 0x0300. Every other register reads 0, and both request outputs are low.
- R2: The countdown may be started only while the halt bit (control-1 bit 0) is 0 and the timer value is greater than 1. With a timer value of 0 or 1, a reload write starts nothing, and ticks produce no expiry and no pulse.
- R3: While the countdown is running, the timer-value-th tick after a start is an expiry, and each expiry sets the timeout bit (status-1 bit 0).
- R4: An expiry that does not reboot reloads the countdown from the timer value, so the reload register reads the timer value again, and the countdown keeps running. It pulses smi_o high for exactly one cycle, in the cycle after the expiry tick, if smi_en_i was high.
- R5: An expiry that follows an earlier expiry with no reload write between them is a second timeout. It sets status-2 bits 0 (second timeout) and 1 (boot), and the count of consecutive expiries starts again from zero.
- R6: On a second timeout with strap_i low and noreboot_i low, reboot_o pulses for one cycle after the expiry tick, the countdown stops and the reload register reads 0. With either input high, the second timeout is handled as in R4.
- R7: A write to the reload register clears the consecutive-expiry count. If the countdown may start, it restarts from the timer value; otherwise the written bytes are stored.
- R8: A read of the reload register returns the ticks remaining while the countdown runs, and the stored reload value while it is stopped.
- R9: Control-1 bit 1 is a lock that software can set but not clear. Any write to control-1 restarts the countdown if the new contents allow it to start, and stops it otherwise.
- R10: A write to the data-in lane (data byte 0) stores the byte, sets status-1 bit 2 and pulses smi_o whatever smi_en_i is. A write to the data-out lane (byte 1) stores the byte and sets status-1 bit 1.
- R11: Writes to status-1, status-2 and control-1 are ANDed with the writable masks 0x0007, 0x0003 and 0x0003. A lane whose strobe is low keeps its old value.
- R12: Control-2, message, timer value and auxiliary registers store the written lanes as they are, with the timer value keeping only its low TMR_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Countdown advance, one step per high cycle |
| strap_i | input | 1 | Strap; when high, it vetoes the reboot request |
| noreboot_i | input | 1 | When high, it vetoes the reboot request |
| smi_en_i | input | 1 | Enables the management interrupt on expiry |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Halfword register index |
| bus_be_i | input | 2 | Byte lane strobes, bit 0 is the low byte |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| smi_o | output | 1 | Management interrupt request pulse |
| reboot_o | output | 1 | Reboot request pulse |

## Verification
The bench builds the block with TMR_W = 6, so a timer-value write of 0xFFFF truncates to 63, and short periods of three or four ticks reach first, second and gated expiries within a few dozen cycles. The consecutive-expiry limit stays at its default of 2, so every expiry alternates between the interrupt path and the reboot decision. The strap and no-reboot inputs are toggled between runs so that each combination of vetoes meets a second timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned A_RELOAD = 0;
  localparam int unsigned A_DATA   = 1;
  localparam int unsigned A_STAT1  = 2;
  localparam int unsigned A_STAT2  = 3;
  localparam int unsigned A_CTRL1  = 4;
  localparam int unsigned A_CTRL2  = 5;
  localparam int unsigned A_MSG    = 6;
  localparam int unsigned A_TMR    = 7;
  localparam int unsigned A_AUX    = 8;

  localparam logic [15:0] STAT1_MASK = 16'h0007;
  localparam logic [15:0] STAT2_MASK = 16'h0003;
  localparam logic [15:0] CTRL1_MASK = 16'h0003;
  localparam logic [15:0] CTRL2_RST  = 16'h0008;
  localparam logic [15:0] AUX_RST    = 16'h0300;
  localparam logic [15:0] TMR_RST    = 16'h0004;

  localparam int unsigned C1_HALT = 0;
  localparam int unsigned C1_LOCK = 1;

  function automatic logic [15:0] lane_merge(input logic [15:0] old_v,
                                             input logic [15:0] new_v,
                                             input logic [1:0]  be);
    logic [15:0] m;
    m = {{8{be[1]}}, {8{be[0]}}};
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sw_load_i,
  input  logic             sw_stop_i,
  input  logic [TMR_W-1:0] load_val_i,
  input  logic             halt_exp_i,
  output logic             running_o,
  output logic [TMR_W-1:0] cnt_o,
  output logic             expire_o
);
  logic             run_q;
  logic [TMR_W-1:0] cnt_q;

  assign expire_o  = run_q & tick_i & (cnt_q == TMR_W'(1)) & ~sw_load_i & ~sw_stop_i;
  assign running_o = run_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (sw_load_i) begin
      run_q <= 1'b1;
      cnt_q <= load_val_i;
    end else if (sw_stop_i) begin
      run_q <= 1'b0;
    end else if (expire_o) begin
      if (halt_exp_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= load_val_i;
      end
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - TMR_W'(1);
    end
  end
endmodule

// File: rtl/wdt_strike.sv
module wdt_strike #(
  parameter int unsigned STRIKES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clr_i,
  input  logic strap_i,
  input  logic noreboot_i,
  output logic second_o,
  output logic reboot_o
);
  localparam int unsigned SW = (STRIKES > 2) ? $clog2(STRIKES) : 1;

  logic [SW-1:0] strikes_q;

  assign second_o = expire_i & (strikes_q == SW'(STRIKES - 1));
  assign reboot_o = second_o & ~strap_i & ~noreboot_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      strikes_q <= '0;
    end else if (expire_i) begin
      strikes_q <= second_o ? '0 : strikes_q + SW'(1);
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned TMR_W  = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        be_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              expire_i,
  input  logic              second_i,
  input  logic              reboot_i,
  input  logic              running_i,
  input  logic [TMR_W-1:0]  cnt_i,
  output logic [TMR_W-1:0]  tmr_o,
  output logic              halt_o,
  output logic              lock_o,
  output logic              sw_load_o,
  output logic              sw_stop_o,
  output logic              strike_clr_o,
  output logic              din_wr_o
);
  logic [15:0]      rld_q, s1_q, s2_q, c1_q, c2_q, msg_q, aux_q;
  logic [7:0]       din_q, dout_q;
  logic [TMR_W-1:0] tmr_q;
  logic [15:0]      rld_n, s1_n, s2_n, c1_w, tmr_x;
  logic             we_rld, we_data, we_s1, we_s2, we_c1;
  logic             can_now, can_new, dout_wr;

  assign tmr_x   = 16'(tmr_q);
  assign we_rld  = wr_i && (addr_i == ADDR_W'(A_RELOAD));
  assign we_data = wr_i && (addr_i == ADDR_W'(A_DATA));
  assign we_s1   = wr_i && (addr_i == ADDR_W'(A_STAT1));
  assign we_s2   = wr_i && (addr_i == ADDR_W'(A_STAT2));
  assign we_c1   = wr_i && (addr_i == ADDR_W'(A_CTRL1));

  assign c1_w    = (lane_merge(c1_q, wdata_i, be_i) & CTRL1_MASK) |
                   (c1_q & (16'h1 << C1_LOCK));
  assign can_now = ~c1_q[C1_HALT] & (tmr_q > TMR_W'(1));
  assign can_new = ~c1_w[C1_HALT] & (tmr_q > TMR_W'(1));

  assign sw_load_o    = (we_rld & can_now) | (we_c1 & can_new);
  assign sw_stop_o    = we_c1 & ~can_new;
  assign strike_clr_o = we_rld;
  assign din_wr_o     = we_data & be_i[0];
  assign dout_wr      = we_data & be_i[1];
  assign tmr_o        = tmr_q;
  assign halt_o       = c1_q[C1_HALT];
  assign lock_o       = c1_q[C1_LOCK];

  always_comb begin
    rld_n = rld_q;
    if (expire_i) rld_n = reboot_i ? 16'h0 : tmr_x;
    if (we_rld) rld_n = can_now ? tmr_x : lane_merge(rld_q, wdata_i, be_i);
    if (we_c1 && can_new) rld_n = tmr_x;
    s1_n = (we_s1 ? (lane_merge(s1_q, wdata_i, be_i) & STAT1_MASK) : s1_q) |
           {13'h0, din_wr_o, dout_wr, expire_i};
    s2_n = (we_s2 ? (lane_merge(s2_q, wdata_i, be_i) & STAT2_MASK) : s2_q) |
           {14'h0, second_i, second_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      c1_q   <= '0;
      c2_q   <= CTRL2_RST;
      msg_q  <= '0;
      aux_q  <= AUX_RST;
      din_q  <= '0;
      dout_q <= '0;
      tmr_q  <= TMR_W'(TMR_RST);
    end else begin
      rld_q <= rld_n;
      s1_q  <= s1_n;
      s2_q  <= s2_n;
      if (we_c1) c1_q <= c1_w;
      if (din_wr_o) din_q <= wdata_i[7:0];
      if (dout_wr) dout_q <= wdata_i[15:8];
      if (wr_i && addr_i == ADDR_W'(A_CTRL2)) c2_q <= lane_merge(c2_q, wdata_i, be_i);
      if (wr_i && addr_i == ADDR_W'(A_MSG)) msg_q <= lane_merge(msg_q, wdata_i, be_i);
      if (wr_i && addr_i == ADDR_W'(A_AUX)) aux_q <= lane_merge(aux_q, wdata_i, be_i);
      if (wr_i && addr_i == ADDR_W'(A_TMR)) tmr_q <= TMR_W'(lane_merge(tmr_x, wdata_i, be_i));
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(A_RELOAD): rdata_o = running_i ? 16'(cnt_i) : rld_q;
      ADDR_W'(A_DATA):   rdata_o = {dout_q, din_q};
      ADDR_W'(A_STAT1):  rdata_o = s1_q;
      ADDR_W'(A_STAT2):  rdata_o = s2_q;
      ADDR_W'(A_CTRL1):  rdata_o = c1_q;
      ADDR_W'(A_CTRL2):  rdata_o = c2_q;
      ADDR_W'(A_MSG):    rdata_o = msg_q;
      ADDR_W'(A_TMR):    rdata_o = tmr_x;
      ADDR_W'(A_AUX):    rdata_o = aux_q;
      default:           rdata_o = 16'h0;
    endcase
  end
endmodule

// File: rtl/mgmt_watchdog.sv
module mgmt_watchdog #(
  parameter int unsigned TMR_W   = 10,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned STRIKES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              strap_i,
  input  logic              noreboot_i,
  input  logic              smi_en_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [1:0]        bus_be_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o,
  output logic              smi_o,
  output logic              reboot_o
);
  logic             expire, second, reboot_now, cd_running;
  logic             sw_load, sw_stop, strike_clr, din_wr, halt, lock;
  logic [TMR_W-1:0] cnt, tmr;

  wdt_countdown #(.TMR_W(TMR_W)) u_cd (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .sw_load_i(sw_load), .sw_stop_i(sw_stop), .load_val_i(tmr),
    .halt_exp_i(reboot_now), .running_o(cd_running), .cnt_o(cnt),
    .expire_o(expire)
  );

  wdt_strike #(.STRIKES(STRIKES)) u_strike (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .clr_i(strike_clr),
    .strap_i(strap_i), .noreboot_i(noreboot_i),
    .second_o(second), .reboot_o(reboot_now)
  );

  wdt_regs #(.TMR_W(TMR_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .be_i(bus_be_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .expire_i(expire), .second_i(second), .reboot_i(reboot_now),
    .running_i(cd_running), .cnt_i(cnt), .tmr_o(tmr), .halt_o(halt),
    .lock_o(lock), .sw_load_o(sw_load), .sw_stop_o(sw_stop),
    .strike_clr_o(strike_clr), .din_wr_o(din_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi_o    <= 1'b0;
      reboot_o <= 1'b0;
    end else begin
      smi_o    <= (expire & ~reboot_now & smi_en_i) | din_wr;
      reboot_o <= reboot_now;
    end
  end
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks (
  input logic clk,
  input logic rst_n,
  input logic strap_i,
  input logic noreboot_i,
  input logic reboot_o,
  input logic running,
  input logic halt,
  input logic lock
);
  // R6: a reboot pulse only follows a cycle with both vetoes low
  a_r6_reboot_gated: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_o |-> $past(!strap_i && !noreboot_i));
  // R6: the countdown is stopped once a reboot is requested
  a_r6_reboot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_o |-> !running);
  // R6: the reboot request lasts a single cycle
  a_r6_reboot_single: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_o |=> !reboot_o);
  // R2: a set halt bit never coexists with a running countdown
  a_r2_halt_blocks_run: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !running);
  // R9: the lock bit never falls outside reset
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> lock);
endmodule

bind mgmt_watchdog wdt_checks u_chk (
  .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .noreboot_i(noreboot_i),
  .reboot_o(reboot_o), .running(cd_running), .halt(halt), .lock(lock)
);

// File: tb/mgmt_watchdog_bench.sv
module mgmt_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 6;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, strap = 1'b0, norb = 1'b0, smi_en = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [1:0] bus_be = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic smi, rb;

  int checks = 0, errors = 0;
  int m_rld, m_din, m_dout, m_s1, m_s2, m_c1, m_c2, m_msg, m_tmr, m_aux;
  int m_cnt, m_run, m_str, m_smi, m_rb;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_watchdog #(.TMR_W(TW)) u_mgmt_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .strap_i(strap), .noreboot_i(norb),
    .smi_en_i(smi_en), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_be_i(bus_be),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .smi_o(smi), .reboot_o(rb)
  );

  function automatic int mrg(input int old_v, input int wd, input int be);
    int m;
    m = ((be & 1) != 0 ? 'hFF : 0) | ((be & 2) != 0 ? 'hFF00 : 0);
    return (old_v & ~m & 'hFFFF) | (wd & m);
  endfunction

  task automatic model_reset();
    m_rld = 0; m_din = 0; m_dout = 0; m_s1 = 0; m_s2 = 0; m_c1 = 0;
    m_c2 = 'h0008; m_msg = 0; m_tmr = 4; m_aux = 'h0300;
    m_cnt = 0; m_run = 0; m_str = 0; m_smi = 0; m_rb = 0;
  endtask

  task automatic model_reload_after_expiry(inout int sm);
    m_rld = m_tmr; m_cnt = m_tmr;
    if (smi_en) sm = 1;
  endtask

  task automatic model(input bit wr, input int a, input int be, input int wd, input bit tk);
    int sm, rbv, nw;
    bit can_now, can_new, swcd;
    sm = 0; rbv = 0;
    can_now = ((m_c1 & 1) == 0) && (m_tmr > 1);
    nw = (mrg(m_c1, wd, be) & 3) | (m_c1 & 2);
    can_new = ((nw & 1) == 0) && (m_tmr > 1);
    swcd = wr && ((a == 0 && can_now) || a == 4);
    if (wr && a == 2) m_s1 = mrg(m_s1, wd, be) & 7;
    if (wr && a == 3) m_s2 = mrg(m_s2, wd, be) & 3;
    if (m_run != 0 && tk && m_cnt == 1 && !swcd) begin
      m_s1 |= 1;
      m_str++;
      if (m_str == 2) begin
        m_s2 |= 3; m_str = 0;
        if (!strap && !norb) begin rbv = 1; m_run = 0; m_rld = 0; m_cnt = 0; end
        else model_reload_after_expiry(sm);
      end else model_reload_after_expiry(sm);
    end else if (m_run != 0 && tk && !swcd) m_cnt--;
    if (wr) begin
      case (a)
        0: begin
          m_str = 0;
          if (can_now) begin m_rld = m_tmr; m_cnt = m_tmr; m_run = 1; end
          else m_rld = mrg(m_rld, wd, be);
        end
        1: begin
          if ((be & 1) != 0) begin m_din = wd & 'hFF; m_s1 |= 4; sm = 1; end
          if ((be & 2) != 0) begin m_dout = (wd >> 8) & 'hFF; m_s1 |= 2; end
        end
        4: begin
          m_c1 = nw;
          if (can_new) begin m_rld = m_tmr; m_cnt = m_tmr; m_run = 1; end
          else m_run = 0;
        end
        5: m_c2 = mrg(m_c2, wd, be);
        6: m_msg = mrg(m_msg, wd, be);
        7: m_tmr = mrg(m_tmr, wd, be) & ((1 << TW) - 1);
        8: m_aux = mrg(m_aux, wd, be);
        default: ;
      endcase
    end
    m_smi = sm; m_rb = rbv;
  endtask

  function automatic int model_read(input int a);
    case (a)
      0: return (m_run != 0) ? m_cnt : m_rld;
      1: return (m_dout << 8) | m_din;
      2: return m_s1;
      3: return m_s2;
      4: return m_c1;
      5: return m_c2;
      6: return m_msg;
      7: return m_tmr;
      8: return m_aux;
      default: return 0;
    endcase
  endfunction

  task automatic step(input bit wr, input int a, input int be, input int wd, input bit tk);
    bus_wr = wr; bus_addr = 4'(a); bus_be = 2'(be); bus_wdata = 16'(wd); tick = tk;
    @(posedge clk);
    model(wr, a, be, wd, tk);
    @(negedge clk);
    checks++;
    if (smi !== 1'(m_smi)) begin
      errors++;
      $display("FAIL R4/R10 smi_o pulse: actual %0b expected %0d", smi, m_smi);
    end
    checks++;
    if (rb !== 1'(m_rb)) begin
      errors++;
      $display("FAIL R6 reboot_o pulse: actual %0b expected %0d", rb, m_rb);
    end
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic wr16(input int a, input int be, input int wd);
    step(1'b1, a, be, wd, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 1'b1);
  endtask

  task automatic rd(input int a, input string req);
    int e;
    bus_addr = 4'(a);
    #1;
    e = model_read(a);
    checks++;
    if (bus_rdata !== 16'(e)) begin
      errors++;
      $display("FAIL %s read idx %0d: actual 0x%04h expected 0x%04h", req, a, bus_rdata, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 10; a++) rd(a, "R1");
    checks++;
    if (smi !== 1'b0 || rb !== 1'b0) begin
      errors++;
      $display("FAIL R1 requests after reset: actual %0b%0b expected 00", smi, rb);
    end
    // R11 masks and lanes
    wr16(2, 3, 'hFFFF); rd(2, "R11");
    wr16(3, 3, 'hFFFF); rd(3, "R11");
    wr16(5, 1, 'hAB55); rd(5, "R11");
    wr16(2, 3, 0); wr16(3, 3, 0); rd(2, "R11"); rd(3, "R11");
    // R12 plain registers
    wr16(6, 3, 'h1234); rd(6, "R12");
    wr16(8, 2, 'hA5FF); rd(8, "R12");
    wr16(7, 3, 'hFFFF); rd(7, "R12");
    // R2 timer values 1 and 0 never start
    wr16(7, 3, 1); wr16(0, 3, 'h00AA); ticks(5); rd(0, "R2"); rd(2, "R2");
    wr16(7, 3, 0); wr16(0, 1, 'h0033); ticks(3); rd(0, "R2");
    // R8 countdown read, R3/R4 first expiry
    smi_en = 1'b1; strap = 1'b1;
    wr16(7, 3, 3); wr16(0, 3, 0); rd(0, "R8");
    ticks(1); rd(0, "R8");
    ticks(2); rd(2, "R3"); rd(0, "R4"); rd(3, "R5");
    // R5 second expiry, strap vetoes reboot
    ticks(3); rd(3, "R5"); rd(0, "R6");
    wr16(3, 3, 0);
    // R6 no-reboot veto, then reboot
    strap = 1'b0; norb = 1'b1;
    ticks(6); rd(3, "R6"); rd(0, "R6");
    norb = 1'b0; wr16(3, 3, 0);
    ticks(6); rd(0, "R6"); rd(3, "R6");
    ticks(4); rd(0, "R6");
    // R7 reload write clears the consecutive count
    wr16(3, 3, 0); wr16(0, 3, 0);
    ticks(3); ticks(1); wr16(0, 3, 0); ticks(3); rd(3, "R7"); rd(0, "R7");
    // R9 halt, lock, restart
    wr16(4, 1, 1); ticks(2); rd(0, "R9"); rd(4, "R9");
    wr16(4, 3, 2); rd(4, "R9"); ticks(1); rd(0, "R9");
    wr16(4, 3, 0); rd(4, "R9"); rd(0, "R9");
    wr16(4, 3, 1); rd(4, "R9"); rd(0, "R9");
    wr16(4, 3, 0);
    // R10 data lanes
    smi_en = 1'b0;
    wr16(2, 3, 0);
    wr16(1, 1, 'h0077); rd(1, "R10"); rd(2, "R10");
    wr16(1, 2, 'h9900); rd(1, "R10"); rd(2, "R10");
    // R4 disabled interrupt on expiry
    wr16(0, 3, 0); ticks(4); rd(2, "R4");
    wr16(7, 3, 4); wr16(0, 3, 0); smi_en = 1'b1; ticks(9); rd(0, "R4");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule